// File: doc/BRIEF.md
# DMA Channel Run-Control Sequencer

This block holds the run state of one DMA channel: off, running or held. Software drives it through two write strobes. One writes the channel enable bit. The other writes the resume controls: a continue flag and a from-start flag. The block then decides when the pointer logic must reload the descriptor pointers from the start addresses and when it must step the source pointer past the current descriptor. It also decides when the fetch engine may fetch the next source descriptor.

Descriptor fetch and data movement sit outside the block. A fetch request is held until it is acknowledged. After the fetch, the movers return one completion report per source descriptor. The report carries a command field, the pointer mode in use (register mode or memory-list mode) and an error flag. From each report the block raises the done or pause event, stops the channel or lets it run on. A held channel can resume in two ways: from its start addresses, or just past the descriptor that caused the hold.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset the status reads 0, the enable and continue readbacks are 0, no fetch request is raised and no event pulse is active.
- R2: The status output reads the state code (0 off, 1 running, 2 held). It reads 3 for as long as an error is latched.
- R3: Any control write that leaves the effective enable at 1 while the channel is off gives a one-cycle reload pulse on the next cycle and moves the status to 1.
- R4: While running with no latched error and no fetch outstanding, the fetch request is held high until fetchAck is seen, then drops. After each completion it rises again if the channel still runs.
- R5: A completion whose command is not halt gives one cycle with both the done and advance pulses.
- R6: A completion in register pointer mode (cplRegMode = 1), or one with command 2 (stop), clears the enable bit. The channel goes off, unless the command is also halt (R7).
- R7: A completion with command 1 (halt) moves the channel to held. It pulses the pause event and gives neither a done pulse nor an advance pulse.
- R8: While held, a control write whose effective enable and continue are both 1 resumes the channel and clears the continue bit. If the from-start flag is 1 it gives a reload pulse; otherwise it gives an advance pulse.
- R9: While held, a control write whose effective enable is 0 and effective continue is 1 moves the channel off with no pointer pulse. With continue at 0 the channel stays held.
- R10: A completion with cplErr = 1 latches the error, clears the enable bit, moves the channel off and gives no event pulse. A later control write whose effective enable is 1 clears the error.
- R11: A completion report that arrives while no fetched descriptor is outstanding is ignored. It causes no pulse and no change of status.
- R12: The command codes 0 and 3 both let the channel run on to the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the enable bit |
| ctlEnVal | input | 1 | Enable value written with ctlWrEn |
| ctlWrMode | input | 1 | Write strobe for the resume controls |
| ctlContVal | input | 1 | Continue flag written with ctlWrMode |
| ctlFromStartVal | input | 1 | From-start flag written with ctlWrMode |
| fetchReq | output | 1 | Request to fetch the next source descriptor |
| fetchAck | input | 1 | Fetch engine accepted the request |
| cplValid | input | 1 | Completion report valid |
| cplCmd | input | CMD_W | Command field of the completed descriptor |
| cplRegMode | input | 1 | 1 = register pointer mode, 0 = memory-list mode |
| cplErr | input | 1 | Fetch of the descriptor failed |
| status | output | 2 | State code, or 3 when an error is latched |
| enableOut | output | 1 | Enable bit readback |
| contOut | output | 1 | Continue bit readback |
| ptrSeed | output | 1 | Pulse: reload pointers from the start addresses and load the first destination descriptor |
| ptrAdvance | output | 1 | Pulse: step the source pointer past the current descriptor |
| doneEvt | output | 1 | Pulse: descriptor processed |
| pauseEvt | output | 1 | Pulse: channel halted by a descriptor |

## Verification
On every cycle, the assertions check the following. The fetch request stays up until it is acknowledged. No request appears while the channel is held or faulted. Done and pause never fire together. Each event pulse agrees with the status it lands in. Only the scenarios can show the rest: which pointer pulse a given resume choice produces, that halt withholds the done event, that the stop command and register mode end a run, that both the continue command codes run on, that a stray completion is ignored, and that the error latch is cleared by an enable write. The scoreboard compares the exact order of pointer and event pulses across these paths.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } runState_t;

  localparam logic [1:0] STATUS_FAULT = 2'd3;

  // Strobes from the control FSM to the register/datapath side.
  typedef struct packed {
    logic clrEnable;
    logic clrCont;
    logic latchErr;
    logic clrErr;
    logic seed;
    logic advance;
    logic done;
    logic pause;
  } ctlStrobe_t;

endpackage

// File: rtl/dma_rc_control.sv
module dma_rc_control
  import dma_rc_pkg::*;
#(
  parameter int CMD_W     = 2,
  parameter int HALT_CODE = 1,
  parameter int STOP_CODE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic             ctlEnVal,
  input  logic             ctlWrMode,
  input  logic             ctlContVal,
  input  logic             ctlFromStartVal,
  input  logic             enQ,
  input  logic             contQ,
  input  logic             fromStartQ,
  input  logic             errQ,
  input  logic             fetchAck,
  input  logic             cplValid,
  input  logic [CMD_W-1:0] cplCmd,
  input  logic             cplRegMode,
  input  logic             cplErr,
  output runState_t        stateQ,
  output logic             fetchReq,
  output ctlStrobe_t       stb
);

  localparam logic [CMD_W-1:0] CmdHalt = CMD_W'(HALT_CODE);
  localparam logic [CMD_W-1:0] CmdStop = CMD_W'(STOP_CODE);

  typedef enum logic {PH_IDLE = 1'b0, PH_BUSY = 1'b1} phase_t;

  phase_t    phaseQ, phaseN;
  runState_t stateN;

  // Effective control values: what the registers hold after this write.
  logic effEn, effCont, effFromStart, anyWr;
  logic isHalt, isStop;

  assign effEn        = ctlWrEn   ? ctlEnVal        : enQ;
  assign effCont      = ctlWrMode ? ctlContVal      : contQ;
  assign effFromStart = ctlWrMode ? ctlFromStartVal : fromStartQ;
  assign anyWr        = ctlWrEn | ctlWrMode;

  assign isHalt = (cplCmd == CmdHalt);
  assign isStop = (cplCmd == CmdStop);

  assign fetchReq = (stateQ == ST_RUN) && !errQ && (phaseQ == PH_IDLE);

  always_comb begin
    stb    = '0;
    stateN = stateQ;
    phaseN = phaseQ;

    if (fetchReq && fetchAck) begin
      phaseN = PH_BUSY;
    end

    if (phaseQ == PH_BUSY && cplValid) begin
      phaseN = PH_IDLE;
      if (cplErr) begin
        stb.latchErr  = 1'b1;
        stb.clrEnable = 1'b1;
        stateN        = ST_OFF;
      end else begin
        if (!isHalt) begin
          stb.done    = 1'b1;
          stb.advance = 1'b1;
        end
        if (cplRegMode || isStop) begin
          stb.clrEnable = 1'b1;
          stateN        = ST_OFF;
        end
        if (isHalt) begin
          stb.pause = 1'b1;
          stateN    = ST_HOLD;
        end
      end
    end else if (anyWr) begin
      if (effEn) begin
        stb.clrErr = 1'b1;
        if (stateQ == ST_HOLD && effCont) begin
          if (effFromStart) stb.seed    = 1'b1;
          else              stb.advance = 1'b1;
          stb.clrCont = 1'b1;
          stateN      = ST_RUN;
        end else if (stateQ == ST_OFF) begin
          stb.seed = 1'b1;
          stateN   = ST_RUN;
        end
      end else if (stateQ == ST_HOLD && effCont) begin
        stateN = ST_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      phaseQ <= PH_IDLE;
    end else begin
      stateQ <= stateN;
      phaseQ <= phaseN;
    end
  end

endmodule

// File: rtl/dma_rc_datapath.sv
module dma_rc_datapath
  import dma_rc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic       ctlEnVal,
  input  logic       ctlWrMode,
  input  logic       ctlContVal,
  input  logic       ctlFromStartVal,
  input  ctlStrobe_t stb,
  input  runState_t  stateQ,
  output logic       enQ,
  output logic       contQ,
  output logic       fromStartQ,
  output logic       errQ,
  output logic [1:0] status,
  output logic       ptrSeed,
  output logic       ptrAdvance,
  output logic       doneEvt,
  output logic       pauseEvt
);

  // Control bits held for software.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      contQ      <= 1'b0;
      fromStartQ <= 1'b0;
    end else begin
      if (stb.clrEnable)  enQ <= 1'b0;
      else if (ctlWrEn)   enQ <= ctlEnVal;

      if (stb.clrCont)    contQ <= 1'b0;
      else if (ctlWrMode) contQ <= ctlContVal;

      if (ctlWrMode)      fromStartQ <= ctlFromStartVal;
    end
  end

  // Error latch: a new fault wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)             errQ <= 1'b0;
    else if (stb.latchErr) errQ <= 1'b1;
    else if (stb.clrErr)   errQ <= 1'b0;
  end

  // Registered one-cycle pulses toward pointer logic and interrupts.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrSeed    <= 1'b0;
      ptrAdvance <= 1'b0;
      doneEvt    <= 1'b0;
      pauseEvt   <= 1'b0;
    end else begin
      ptrSeed    <= stb.seed;
      ptrAdvance <= stb.advance;
      doneEvt    <= stb.done;
      pauseEvt   <= stb.pause;
    end
  end

  assign status = errQ ? STATUS_FAULT : stateQ;

endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import dma_rc_pkg::*;
#(
  parameter int CMD_W     = 2,
  parameter int HALT_CODE = 1,
  parameter int STOP_CODE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic             ctlEnVal,
  input  logic             ctlWrMode,
  input  logic             ctlContVal,
  input  logic             ctlFromStartVal,
  output logic             fetchReq,
  input  logic             fetchAck,
  input  logic             cplValid,
  input  logic [CMD_W-1:0] cplCmd,
  input  logic             cplRegMode,
  input  logic             cplErr,
  output logic [1:0]       status,
  output logic             enableOut,
  output logic             contOut,
  output logic             ptrSeed,
  output logic             ptrAdvance,
  output logic             doneEvt,
  output logic             pauseEvt
);

  ctlStrobe_t stb;
  runState_t  stateQ;
  logic       enQ, contQ, fromStartQ, errQ;

  dma_rc_control #(
    .CMD_W    (CMD_W),
    .HALT_CODE(HALT_CODE),
    .STOP_CODE(STOP_CODE)
  ) i_control (
    .clk            (clk),
    .rstN           (rstN),
    .ctlWrEn        (ctlWrEn),
    .ctlEnVal       (ctlEnVal),
    .ctlWrMode      (ctlWrMode),
    .ctlContVal     (ctlContVal),
    .ctlFromStartVal(ctlFromStartVal),
    .enQ            (enQ),
    .contQ          (contQ),
    .fromStartQ     (fromStartQ),
    .errQ           (errQ),
    .fetchAck       (fetchAck),
    .cplValid       (cplValid),
    .cplCmd         (cplCmd),
    .cplRegMode     (cplRegMode),
    .cplErr         (cplErr),
    .stateQ         (stateQ),
    .fetchReq       (fetchReq),
    .stb            (stb)
  );

  dma_rc_datapath i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .ctlWrEn        (ctlWrEn),
    .ctlEnVal       (ctlEnVal),
    .ctlWrMode      (ctlWrMode),
    .ctlContVal     (ctlContVal),
    .ctlFromStartVal(ctlFromStartVal),
    .stb            (stb),
    .stateQ         (stateQ),
    .enQ            (enQ),
    .contQ          (contQ),
    .fromStartQ     (fromStartQ),
    .errQ           (errQ),
    .status         (status),
    .ptrSeed        (ptrSeed),
    .ptrAdvance     (ptrAdvance),
    .doneEvt        (doneEvt),
    .pauseEvt       (pauseEvt)
  );

  assign enableOut = enQ;
  assign contOut   = contQ;

endmodule

// File: rtl/dma_run_ctrl_chk.sv
module dma_run_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fetchReq,
  input logic       fetchAck,
  input logic [1:0] status,
  input logic       ptrSeed,
  input logic       ptrAdvance,
  input logic       doneEvt,
  input logic       pauseEvt
);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> fetchReq);

  p_no_req_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd2) |-> !fetchReq);

  p_no_req_fault_r10: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd3) |-> !fetchReq);

  p_pause_no_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(doneEvt && pauseEvt));

  p_pause_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    pauseEvt |-> (status == 2'd2));

  p_done_advances_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> ptrAdvance);

  p_seed_runs_r3: assert property (@(posedge clk) disable iff (!rstN)
    ptrSeed |-> (status == 2'd1));

  p_seed_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ptrSeed, ptrAdvance, pauseEvt}) || (ptrAdvance && doneEvt && !ptrSeed && !pauseEvt));

endmodule

bind dma_run_ctrl dma_run_ctrl_chk i_chk (.*);

// File: tb/test_dma_run_ctrl.sv
module test_dma_run_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrEn = 1'b0, ctlEnVal = 1'b0;
  logic       ctlWrMode = 1'b0, ctlContVal = 1'b0, ctlFromStartVal = 1'b0;
  logic       fetchAck = 1'b0;
  logic       cplValid = 1'b0, cplRegMode = 1'b0, cplErr = 1'b0;
  logic [1:0] cplCmd = 2'd0;
  logic       fetchReq, enableOut, contOut;
  logic       ptrSeed, ptrAdvance, doneEvt, pauseEvt;
  logic [1:0] status;

  int total = 0;
  int bad   = 0;

  // Expected pulse vectors {seed, advance, done, pause}.
  logic [3:0] expQ[$];

  always #5 clk = ~clk;

  dma_run_ctrl i_dma_run_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlEnVal(ctlEnVal),
    .ctlWrMode(ctlWrMode), .ctlContVal(ctlContVal), .ctlFromStartVal(ctlFromStartVal),
    .fetchReq(fetchReq), .fetchAck(fetchAck),
    .cplValid(cplValid), .cplCmd(cplCmd), .cplRegMode(cplRegMode), .cplErr(cplErr),
    .status(status), .enableOut(enableOut), .contOut(contOut),
    .ptrSeed(ptrSeed), .ptrAdvance(ptrAdvance), .doneEvt(doneEvt), .pauseEvt(pauseEvt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Monitor: every observed pulse vector must match the next expected item.
  always @(negedge clk) begin
    if (rstN) begin
      logic [3:0] seen;
      seen = {ptrSeed, ptrAdvance, doneEvt, pauseEvt};
      if (seen != 4'd0) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5 R7 R8 R11 unexpected pulse", int'(seen), 0);
        end else begin
          logic [3:0] e;
          e = expQ.pop_front();
          chkEq("R3 R5 R7 R8 pulse order", int'(seen), int'(e));
        end
      end
    end
  end

  task automatic wrEn(input logic v, input logic [3:0] exp);
    @(negedge clk);
    if (exp != 4'd0) expQ.push_back(exp);
    ctlWrEn = 1'b1; ctlEnVal = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic wrMode(input logic c, input logic fs, input logic [3:0] exp);
    @(negedge clk);
    if (exp != 4'd0) expQ.push_back(exp);
    ctlWrMode = 1'b1; ctlContVal = c; ctlFromStartVal = fs;
    @(negedge clk);
    ctlWrMode = 1'b0;
  endtask

  task automatic serve();
    int n;
    n = 0;
    @(negedge clk);
    while (!fetchReq && n < 20) begin
      @(negedge clk);
      n++;
    end
    chkEq("R4 fetch request raised", int'(fetchReq), 1);
    fetchAck = 1'b1;
    @(negedge clk);
    fetchAck = 1'b0;
    chkEq("R4 request drops after ack", int'(fetchReq), 0);
  endtask

  task automatic complete(input logic [1:0] cmd, input logic rm, input logic er,
                          input logic [3:0] exp);
    if (exp != 4'd0) expQ.push_back(exp);
    cplValid = 1'b1; cplCmd = cmd; cplRegMode = rm; cplErr = er;
    @(negedge clk);
    cplValid = 1'b0; cplRegMode = 1'b0; cplErr = 1'b0; cplCmd = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 status", int'(status), 0);
    chkEq("R1 enable", int'(enableOut), 0);
    chkEq("R1 continue", int'(contOut), 0);
    chkEq("R1 fetch", int'(fetchReq), 0);
    chkEq("R1 pulses", int'({ptrSeed, ptrAdvance, doneEvt, pauseEvt}), 0);

    // R3 start from off
    wrEn(1'b1, 4'b1000);
    chkEq("R3 status running", int'(status), 1);
    chkEq("R3 enable readback", int'(enableOut), 1);
    // R4 request held without ack
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chkEq("R4 request held", int'(fetchReq), 1);
    end
    serve();
    // R5 normal completion
    complete(2'd0, 1'b0, 1'b0, 4'b0110);
    chkEq("R5 still running", int'(status), 1);
    chkEq("R4 next request", int'(fetchReq), 1);
    serve();
    // R12 command 3 runs on
    complete(2'd3, 1'b0, 1'b0, 4'b0110);
    chkEq("R12 command 3 runs on", int'(status), 1);
    serve();
    // R6 stop
    complete(2'd2, 1'b0, 1'b0, 4'b0110);
    chkEq("R6 stop goes off", int'(status), 0);
    chkEq("R6 stop clears enable", int'(enableOut), 0);
    chkEq("R6 no request when off", int'(fetchReq), 0);

    // R6 register mode ends after one descriptor
    wrEn(1'b1, 4'b1000);
    serve();
    complete(2'd0, 1'b1, 1'b0, 4'b0110);
    chkEq("R6 register mode goes off", int'(status), 0);
    chkEq("R6 register mode clears enable", int'(enableOut), 0);

    // R7 halt
    wrEn(1'b1, 4'b1000);
    serve();
    complete(2'd1, 1'b0, 1'b0, 4'b0001);
    chkEq("R7 halt holds", int'(status), 2);
    chkEq("R7 enable kept", int'(enableOut), 1);
    repeat (2) @(negedge clk);
    chkEq("R7 no request while held", int'(fetchReq), 0);
    // R11 stray completion
    complete(2'd0, 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    chkEq("R11 stray completion ignored", int'(status), 2);

    // R8 resume past halted descriptor
    wrMode(1'b1, 1'b0, 4'b0100);
    chkEq("R8 resume runs", int'(status), 1);
    chkEq("R8 continue cleared", int'(contOut), 0);
    serve();
    complete(2'd1, 1'b0, 1'b0, 4'b0001);
    // R8 resume from start
    wrMode(1'b1, 1'b1, 4'b1000);
    chkEq("R8 resume from start runs", int'(status), 1);
    serve();
    complete(2'd1, 1'b0, 1'b0, 4'b0001);

    // R9 enable off then continue
    wrEn(1'b0, 4'b0000);
    chkEq("R9 held without continue", int'(status), 2);
    chkEq("R9 enable readback", int'(enableOut), 0);
    wrMode(1'b1, 1'b0, 4'b0000);
    chkEq("R9 held to off", int'(status), 0);

    // R10 error
    wrEn(1'b1, 4'b1000);
    serve();
    complete(2'd0, 1'b0, 1'b1, 4'b0000);
    chkEq("R10 fault status", int'(status), 3);
    chkEq("R10 enable cleared", int'(enableOut), 0);
    chkEq("R10 no request", int'(fetchReq), 0);
    complete(2'd0, 1'b0, 1'b0, 4'b0000);
    chkEq("R11 stray completion after fault", int'(status), 3);
    wrEn(1'b1, 4'b1000);
    chkEq("R10 enable write clears fault", int'(status), 1);
    serve();
    complete(2'd2, 1'b0, 1'b0, 4'b0110);
    chkEq("R2 off after stop", int'(status), 0);

    // R7 halt in register mode: held, enable cleared
    wrEn(1'b1, 4'b1000);
    serve();
    complete(2'd1, 1'b1, 1'b0, 4'b0001);
    chkEq("R7 halt wins over register mode", int'(status), 2);
    chkEq("R6 register mode clears enable on halt", int'(enableOut), 0);

    repeat (3) @(negedge clk);
    chkEq("R5 all expected pulses seen", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule